// File: doc/BRIEF.md
# Checkerboard memory test pattern generator

This block is a small algorithmic pattern engine that tests a square-organised memory. A start pulse begins the walk. A row register and a column register then step through the cells in raster order. The column is the inner loop. When the column reaches its programmed limit, it wraps to zero and the row advances. The limits are runtime inputs, so the same engine can test a whole array or any smaller corner of it.

The engine does not store a data pattern. It computes the expected word from the low address bits, which gives a checkerboard, and a polarity input gives the complementary board. Each cell takes three cycles:

- a write cycle;
- a read-issue cycle;
- a compare cycle, which samples the read data returned with one cycle of latency.

A mismatch ends the test at once. It raises a sticky fail flag and records the failing row and column. If every cell matches, the engine raises done with fail low.

Top module: `ckbd_mem_tester`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, mem_we_o and mem_re_o are low and fail_row_o and fail_col_o are zero.
- R2: Cells are visited with the column incrementing from 0 up to and including col_max_i. From col_max_i the column returns to 0 and the row increments. The walk covers rows 0 up to and including row_max_i, and no address outside these bounds is written.
- R3: Each cell uses three cycles: a write (mem_we_o high), a read issue at the same address on the next cycle (mem_re_o high), and a compare on the cycle after that. busy_o is high for exactly 3 cycles per tested cell.
- R4: With invert_i low, every bit of the write data equals row[0] XOR col[0].
- R5: With invert_i high, every bit of the write data equals NOT(row[0] XOR col[0]).
- R6: If the data read back differs from the data written, fail_o and done_o rise together, busy_o falls, no further cell is written, and fail_row_o/fail_col_o hold that cell's address.
- R7: done_o and fail_o stay set until the next accepted start, and a start clears both on the following cycle.
- R8: A start pulse while busy_o is high has no effect.
- R9: row_max_i, col_max_i and invert_i are sampled only when a start is accepted. Changes during a run do not alter that run.
- R10: mem_we_o and mem_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| row_max_i | input | ROW_W | Last row to test (inclusive) |
| col_max_i | input | COL_W | Last column to test (inclusive) |
| invert_i | input | 1 | Selects the complementary checkerboard |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe, data returned next cycle |
| mem_row_o | output | ROW_W | Row address |
| mem_col_o | output | COL_W | Column address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after mem_re_o |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished (sticky) |
| fail_o | output | 1 | Mismatch seen (sticky) |
| fail_row_o | output | ROW_W | Row of the failing cell |
| fail_col_o | output | COL_W | Column of the failing cell |

## Verification
The walk runs against a model memory:
- Full, single-cell and oddly shaped regions, in both polarities, check the wrap point and the inclusive limits.
- A fault injected on read at the first cell, at the last cell and outside the region separates correct early termination from a walk that runs past a failure or strays beyond its bounds.
- A restart pulse and new configuration values applied mid-run show whether start and the configuration are sampled only when idle.

Random regions and fault positions from a fixed seed cover the remaining combinations.

// File: rtl/ckbd_pkg.sv
package ckbd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_CMP  = 2'd3
  } step_e;
endpackage

// File: rtl/ckbd_addr_walk.sv
module ckbd_addr_walk #(
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [ROW_W-1:0] row_max_i,
  input  logic [COL_W-1:0] col_max_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             last_o
);
  logic [ROW_W-1:0] row_q, row_max_q;
  logic [COL_W-1:0] col_q, col_max_q;
  logic             col_end;

  assign col_end = (col_q == col_max_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q     <= '0;
      col_q     <= '0;
      row_max_q <= '0;
      col_max_q <= '0;
    end else if (load_i) begin
      row_q     <= '0;
      col_q     <= '0;
      row_max_q <= row_max_i;
      col_max_q <= col_max_i;
    end else if (adv_i) begin
      if (col_end) begin
        col_q <= '0;
        row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign last_o = col_end && (row_q == row_max_q);

  // R2: an advance never runs past the latched limits
  a_r2_col_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i |=> col_q <= col_max_q && row_q <= row_max_q);
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && $past(1'b1) |=> (col_q == '0) || (row_q == $past(row_q)));
endmodule

// File: rtl/ckbd_pattern.sv
module ckbd_pattern #(
  parameter int DATA_W = 4
) (
  input  logic              row_lsb_i,
  input  logic              col_lsb_i,
  input  logic              invert_i,
  output logic [DATA_W-1:0] data_o
);
  logic cell_bit;
  assign cell_bit = row_lsb_i ^ col_lsb_i ^ invert_i;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign data_o[i] = cell_bit;
  end
endmodule

// File: rtl/ckbd_seq.sv
module ckbd_seq
  import ckbd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  input  logic match_i,
  output logic load_o,
  output logic adv_o,
  output logic cap_o,
  output logic we_o,
  output logic re_o,
  output logic busy_o,
  output logic done_o,
  output logic fail_o
);
  step_e st_q;
  logic  done_q, fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_WR;
          done_q <= 1'b0;
          fail_q <= 1'b0;
        end
        ST_WR: st_q <= ST_RD;
        ST_RD: st_q <= ST_CMP;
        ST_CMP: begin
          if (!match_i) begin
            fail_q <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (last_i) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_WR;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign adv_o  = (st_q == ST_CMP) && match_i && !last_i;
  assign cap_o  = (st_q == ST_CMP) && !match_i;
  assign we_o   = (st_q == ST_WR);
  assign re_o   = (st_q == ST_RD);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;

  // R3: write is followed by read issue, then by a non-strobe compare cycle
  a_r3_wr_then_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> re_o);
  a_r3_rd_then_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> busy_o && !we_o && !re_o);
  // R7: flags hold while no start arrives
  a_r7_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);
  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  // R8: a start while busy does not restart the walk
  a_r8_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !we_o && !re_o && match_i && !last_i && start_i |=> we_o);
endmodule

// File: rtl/ckbd_mem_tester.sv
module ckbd_mem_tester #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ROW_W-1:0]  row_max_i,
  input  logic [COL_W-1:0]  col_max_i,
  input  logic              invert_i,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ROW_W-1:0]  mem_row_o,
  output logic [COL_W-1:0]  mem_col_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ROW_W-1:0]  fail_row_o,
  output logic [COL_W-1:0]  fail_col_o
);
  logic load, adv, cap, last, match, inv_q;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [DATA_W-1:0] exp_data;
  logic [ROW_W-1:0]  fail_row_q;
  logic [COL_W-1:0]  fail_col_q;

  ckbd_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .last_i  (last),
    .match_i (match),
    .load_o  (load),
    .adv_o   (adv),
    .cap_o   (cap),
    .we_o    (mem_we_o),
    .re_o    (mem_re_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .fail_o  (fail_o)
  );

  ckbd_addr_walk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .adv_i     (adv),
    .row_max_i (row_max_i),
    .col_max_i (col_max_i),
    .row_o     (row),
    .col_o     (col),
    .last_o    (last)
  );

  ckbd_pattern #(.DATA_W(DATA_W)) u_pat (
    .row_lsb_i (row[0]),
    .col_lsb_i (col[0]),
    .invert_i  (inv_q),
    .data_o    (exp_data)
  );

  // Polarity latched with the limits; capture cleared on start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q      <= 1'b0;
      fail_row_q <= '0;
      fail_col_q <= '0;
    end else if (load) begin
      inv_q      <= invert_i;
      fail_row_q <= '0;
      fail_col_q <= '0;
    end else if (cap) begin
      fail_row_q <= row;
      fail_col_q <= col;
    end
  end

  assign match       = (mem_rdata_i == exp_data);
  assign mem_row_o   = row;
  assign mem_col_o   = col;
  assign mem_wdata_o = exp_data;
  assign fail_row_o  = fail_row_q;
  assign fail_col_o  = fail_col_q;

  // R10
  a_r10_we_re_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
  // R6: fail always comes with done, and ends activity
  a_r6_fail_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o);
  a_r6_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> !busy_o && !mem_we_o);
  // R3: address is held between write and read issue
  a_r3_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> $stable(mem_row_o) && $stable(mem_col_o));
endmodule

// File: tb/tb_ckbd_mem_tester.sv
module tb_ckbd_mem_tester;
  localparam int ROW_W = 3, COL_W = 3, DATA_W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, inv = 1'b0;
  logic [ROW_W-1:0] rmax = '0;
  logic [COL_W-1:0] cmax = '0;
  logic we, re, busy, done, fail;
  logic [ROW_W-1:0] row, frow;
  logic [COL_W-1:0] col, fcol;
  logic [DATA_W-1:0] wdata, rdata;

  always #5 clk = ~clk;

  ckbd_mem_tester #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .row_max_i(rmax), .col_max_i(cmax),
    .invert_i(inv), .mem_we_o(we), .mem_re_o(re), .mem_row_o(row), .mem_col_o(col),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_row_o(frow), .fail_col_o(fcol));

  // model memory with read-path fault injection
  logic [DATA_W-1:0] mem [64];
  logic              flt_en = 1'b0;
  logic [ROW_W-1:0]  flt_r = '0;
  logic [COL_W-1:0]  flt_c = '0;
  logic [DATA_W-1:0] flt_m = '0;
  always_ff @(posedge clk) begin
    if (we) mem[{row, col}] <= wdata;
    if (re) rdata <= mem[{row, col}] ^ ((flt_en && row == flt_r && col == flt_c) ? flt_m : '0);
  end

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_word(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c, input logic iv);
    return {DATA_W{r[0] ^ c[0] ^ iv}};
  endfunction

  // monitor: run config and expected walk position
  logic [ROW_W-1:0] run_rmax, exp_r;
  logic [COL_W-1:0] run_cmax, exp_c;
  logic run_inv;
  int wr_cnt, busy_cnt, ord_err, dat_err, out_err;
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (we) begin
      wr_cnt++;
      if (row != exp_r || col != exp_c) ord_err++;
      if (row > run_rmax || col > run_cmax) out_err++;
      if (wdata != exp_word(row, col, run_inv)) dat_err++;
      if (exp_c == run_cmax) begin exp_c = '0; exp_r = exp_r + 1'b1; end
      else exp_c = exp_c + 1'b1;
    end
  end

  bit wd_hit = 1'b0;
  task automatic run(input logic [ROW_W-1:0] r_m, input logic [COL_W-1:0] c_m, input logic iv,
                     input bit fe, input logic [ROW_W-1:0] fr, input logic [COL_W-1:0] fc,
                     input bit perturb, input string tag);
    int n, k, wait_n;
    bit exp_fail;
    n = (int'(r_m) + 1) * (int'(c_m) + 1);
    exp_fail = fe && fr <= r_m && fc <= c_m;
    k = exp_fail ? int'(fr) * (int'(c_m) + 1) + int'(fc) + 1 : n;
    flt_en = fe; flt_r = fr; flt_c = fc; flt_m = DATA_W'(1) << ($urandom % DATA_W);
    @(negedge clk);
    rmax = r_m; cmax = c_m; inv = iv; start = 1'b1;
    run_rmax = r_m; run_cmax = c_m; run_inv = iv;
    exp_r = '0; exp_c = '0; wr_cnt = 0; busy_cnt = 0; ord_err = 0; dat_err = 0; out_err = 0;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done && !fail, "R7", {tag, " start clears flags"}, {busy, done, fail}, 3'b100);
    wait_n = 0;
    while (!done && wait_n < 2000) begin
      if (perturb && wait_n == 4) begin
        start = 1'b1; rmax = ~r_m; cmax = ~c_m; inv = ~iv;
      end else start = 1'b0;
      @(negedge clk);
      wait_n++;
    end
    start = 1'b0;
    if (wait_n >= 2000) begin wd_hit = 1'b1; chk(0, "R3", {tag, " watchdog"}, wait_n, 3 * k); return; end
    chk(fail == exp_fail, "R6", {tag, " fail flag"}, fail, exp_fail);
    chk(wr_cnt == k, "R2", {tag, " cells written"}, wr_cnt, k);
    chk(busy_cnt == 3 * k, "R3", {tag, " busy cycles"}, busy_cnt, 3 * k);
    chk(ord_err == 0 && out_err == 0, "R2", {tag, " raster order/bounds"}, ord_err + out_err, 0);
    chk(dat_err == 0, iv ? "R5" : "R4", {tag, " pattern data"}, dat_err, 0);
    if (exp_fail)
      chk(frow == fr && fcol == fc, "R6", {tag, " fail address"}, {frow, fcol}, {fr, fc});
    if (perturb) chk(ord_err == 0 && wr_cnt == k, "R8", {tag, " restart/cfg mid-run ignored (R9)"}, wr_cnt, k);
    repeat (4) @(negedge clk);
    chk(done && fail == exp_fail && !busy && wr_cnt == k, "R7", {tag, " flags sticky, no more writes"},
        {done, fail, busy}, {1'b1, exp_fail, 1'b0});
  endtask

  initial begin
    #2000000;
    wd_hit = 1'b1;
    total++; bad++;
    $display("FAIL R3 global watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !we && !re && frow == 0 && fcol == 0, "R1", "reset state",
        {busy, done, fail, we, re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !we && !re, "R1", "idle after reset", {busy, we, re}, 0);

    run(3'd7, 3'd7, 1'b0, 0, '0, '0, 0, "full xor");
    run(3'd7, 3'd7, 1'b1, 0, '0, '0, 0, "full xnor");
    run(3'd0, 3'd0, 1'b0, 0, '0, '0, 0, "single cell");
    run(3'd7, 3'd7, 1'b1, 1, 3'd0, 3'd0, 0, "fault first");
    run(3'd5, 3'd2, 1'b0, 1, 3'd5, 3'd2, 0, "fault last");
    run(3'd2, 3'd3, 1'b0, 1, 3'd6, 3'd1, 0, "fault outside");
    run(3'd3, 3'd4, 1'b1, 0, '0, '0, 1, "mid-run restart");
    run(3'd4, 3'd4, 1'b0, 1, 3'd2, 3'd3, 1, "mid-run fault");
    for (int i = 0; i < 20; i++) begin
      logic [ROW_W-1:0] rr, fr;
      logic [COL_W-1:0] cc, fc;
      rr = ROW_W'($urandom); cc = COL_W'($urandom);
      fr = ROW_W'($urandom); fc = COL_W'($urandom);
      run(rr, cc, 1'($urandom), 1'($urandom), fr, fc, 0, $sformatf("rand%0d", i));
    end
    if (!wd_hit) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule